// File: doc/BRIEF.md
# Per-Instruction Stride Prefetcher

This block sits beside a data cache's load port and watches each accepted load. Every load arrives with two addresses: the address of the instruction that issued it and the data address it touches. A small direct-mapped table, indexed by low instruction-address bits, remembers for each tracked instruction the previous data address, the distance between its last two accesses, and a saturating confidence count.

Once one instruction steps through memory by the same nonzero distance several times in a row, the block emits a prefetch request. The request targets the current data address plus that distance, and it appears one cycle after the load that triggered it. Distances may be positive or negative. Distances beyond a fixed magnitude bound are treated as irregular and never lead to a prefetch.

Cache arrays, line fill and filtering against lines already present are left to the surrounding logic.

Top module: `load_stride_prefetcher`

## Requirements
- R1: After reset `pf_valid` and `pf_addr` are 0. Every table entry is empty, so the first load from any instruction is a miss.
- R2: The table entry is selected by `load_pc[3:0]`, and `load_pc[11:4]` is stored as a tag. A load whose index matches but whose tag differs is a miss and replaces the entry.
- R3: A miss writes the tag and data address into the entry, sets the stored stride and confidence to 0, and produces no prefetch.
- R4: On a hit, when the new distance equals the stored nonzero stride, confidence rises by one and saturates at 3. Any other in-range nonzero distance replaces the stored stride and sets confidence to 0.
- R5: A hit whose updated confidence is 2 or more produces `pf_valid`=1 in the cycle after the load, with `pf_addr` = data address + stride, wrapping modulo 2^32. With a constant stride, the fourth load of an instruction is the first to prefetch.
- R6: Negative strides are learned and prefetched in the same way as positive ones.
- R7: A distance whose magnitude exceeds 2048 bytes clears stride and confidence and never prefetches. A distance of exactly 2048 is tracked.
- R8: A zero distance clears stride and confidence and never prefetches.
- R9: At most one prefetch follows each load. `pf_valid` is 1 only in the cycle directly after a cycle with `load_valid`=1.
- R10: Instructions that map to different entries learn their strides independently, even when their loads are interleaved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | A load is observed this cycle |
| load_pc | input | 32 | Address of the issuing load instruction |
| load_addr | input | 32 | Data address of the load |
| pf_valid | output | 1 | Prefetch request valid |
| pf_addr | output | 32 | Prefetch target address |

## Verification
Several rules are checked by the assertions on every cycle:
- a prefetch only ever follows a load;
- a miss, a zero distance, an out-of-range distance or a freshly changed stride never yields a prefetch;
- every prefetch target lies within the stride bound of the load that produced it and differs from that load's address.

Other behaviour builds up over several loads, so only the bench's scenarios show it:
- the exact load on which confidence first reaches the firing level;
- saturation of the confidence count and its loss after one irregular step;
- eviction through an index alias;
- independent learning by interleaved instructions.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

  // Classification of one observed load against its table entry.
  typedef enum logic [2:0] {
    EV_IDLE      = 3'd0,
    EV_MISS      = 3'd1,
    EV_MATCH     = 3'd2,
    EV_NEWSTRIDE = 3'd3,
    EV_ZERO      = 3'd4,
    EV_FAR       = 3'd5
  } lsp_event_e;

  // Saturating increment used for the confidence counter.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned maxv);
    return (v >= maxv) ? maxv : v + 1;
  endfunction

endpackage

// File: rtl/lsp_table.sv
module lsp_table #(
  parameter int ENTRIES  = 16,
  parameter int TAG_W    = 8,
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 13,
  parameter int CONF_W   = 2,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic                rd_valid,
  output logic [TAG_W-1:0]    rd_tag,
  output logic [ADDR_W-1:0]   rd_addr,
  output logic [STRIDE_W-1:0] rd_stride,
  output logic [CONF_W-1:0]   rd_conf,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [STRIDE_W-1:0] wr_stride,
  input  logic [CONF_W-1:0]   wr_conf
);

  logic                valid_q  [ENTRIES];
  logic [TAG_W-1:0]    tag_q    [ENTRIES];
  logic [ADDR_W-1:0]   addr_q   [ENTRIES];
  logic [STRIDE_W-1:0] stride_q [ENTRIES];
  logic [CONF_W-1:0]   conf_q   [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic hit_w;
    assign hit_w = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[e]  <= 1'b0;
        tag_q[e]    <= '0;
        addr_q[e]   <= '0;
        stride_q[e] <= '0;
        conf_q[e]   <= '0;
      end else if (hit_w) begin
        valid_q[e]  <= 1'b1;
        tag_q[e]    <= wr_tag;
        addr_q[e]   <= wr_addr;
        stride_q[e] <= wr_stride;
        conf_q[e]   <= wr_conf;
      end
    end

    // R3: once written, an entry is never empty again before reset
    assert_entry_stays_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q[e] |=> valid_q[e]);
  end

  assign rd_valid  = valid_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];
  assign rd_addr   = addr_q[rd_idx];
  assign rd_stride = stride_q[rd_idx];
  assign rd_conf   = conf_q[rd_idx];

endmodule

// File: rtl/lsp_classify.sv
module lsp_classify
  import lsp_pkg::*;
#(
  parameter int TAG_W      = 8,
  parameter int ADDR_W     = 32,
  parameter int STRIDE_W   = 13,
  parameter int CONF_W     = 2,
  parameter int MAX_STRIDE = 2048,
  parameter int CONF_FIRE  = 2,
  localparam int CONF_MAX  = (1 << CONF_W) - 1
) (
  input  logic                load_valid,
  input  logic [TAG_W-1:0]    load_tag,
  input  logic [ADDR_W-1:0]   load_addr,
  input  logic                ent_valid,
  input  logic [TAG_W-1:0]    ent_tag,
  input  logic [ADDR_W-1:0]   ent_addr,
  input  logic [STRIDE_W-1:0] ent_stride,
  input  logic [CONF_W-1:0]   ent_conf,
  output lsp_event_e          ev,
  output logic                wr_en,
  output logic [STRIDE_W-1:0] wr_stride,
  output logic [CONF_W-1:0]   wr_conf,
  output logic                fire,
  output logic [ADDR_W-1:0]   target
);

  // Distance bound test on the full-width signed difference.
  function automatic logic within_bound(input logic [ADDR_W-1:0] d);
    logic signed [ADDR_W:0] s;
    s = {d[ADDR_W-1], d};
    return (s <= (ADDR_W+1)'(MAX_STRIDE)) && (s >= -(ADDR_W+1)'(MAX_STRIDE));
  endfunction

  function automatic logic [ADDR_W-1:0] widen(input logic [STRIDE_W-1:0] s);
    return {{(ADDR_W-STRIDE_W){s[STRIDE_W-1]}}, s};
  endfunction

  logic [ADDR_W-1:0]   diff;
  logic [STRIDE_W-1:0] diff_n;
  logic                hit;
  logic [CONF_W-1:0]   conf_up;

  assign hit     = ent_valid && (ent_tag == load_tag);
  assign diff    = load_addr - ent_addr;
  assign diff_n  = diff[STRIDE_W-1:0];
  assign conf_up = CONF_W'(sat_inc(int'(ent_conf), CONF_MAX));
  assign target  = load_addr + widen(ent_stride);
  assign wr_en   = load_valid;

  always_comb begin
    ev        = EV_IDLE;
    wr_stride = '0;
    wr_conf   = '0;
    fire      = 1'b0;
    if (load_valid) begin
      if (!hit) begin
        ev = EV_MISS;
      end else if (diff == '0) begin
        ev = EV_ZERO;
      end else if (!within_bound(diff)) begin
        ev = EV_FAR;
      end else if (diff_n == ent_stride) begin
        ev        = EV_MATCH;
        wr_stride = ent_stride;
        wr_conf   = conf_up;
        fire      = (conf_up >= CONF_W'(CONF_FIRE));
      end else begin
        ev        = EV_NEWSTRIDE;
        wr_stride = diff_n;
      end
    end
  end

  // R8: a stored stride used for a match is never zero
  always_comb begin
    if (ev == EV_MATCH) assert_match_nonzero_R8: assert (ent_stride != '0);
  end

endmodule

// File: rtl/lsp_issue.sv
module lsp_issue #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] target,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else begin
      pf_valid <= fire;
      if (fire) pf_addr <= target;
    end
  end

endmodule

// File: rtl/load_stride_prefetcher.sv
module load_stride_prefetcher
  import lsp_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 16,
  parameter int TAG_W      = 8,
  parameter int CONF_W     = 2,
  parameter int MAX_STRIDE = 2048,
  parameter int CONF_FIRE  = 2,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int STRIDE_W  = $clog2(MAX_STRIDE) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic [PC_W-1:0]   load_pc,
  input  logic [ADDR_W-1:0] load_addr,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);

  logic [IDX_W-1:0]    idx;
  logic [TAG_W-1:0]    tag;
  logic                ent_valid;
  logic [TAG_W-1:0]    ent_tag;
  logic [ADDR_W-1:0]   ent_addr;
  logic [STRIDE_W-1:0] ent_stride;
  logic [CONF_W-1:0]   ent_conf;
  lsp_event_e          ev;
  logic                wr_en;
  logic [STRIDE_W-1:0] wr_stride;
  logic [CONF_W-1:0]   wr_conf;
  logic                fire;
  logic [ADDR_W-1:0]   target;

  // Named internal events for the checks below
  logic ev_miss, ev_zero, ev_far, ev_restride;

  assign idx = load_pc[IDX_W-1:0];
  assign tag = load_pc[IDX_W +: TAG_W];

  lsp_table #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W),
    .STRIDE_W(STRIDE_W), .CONF_W(CONF_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(idx), .rd_valid(ent_valid), .rd_tag(ent_tag), .rd_addr(ent_addr),
    .rd_stride(ent_stride), .rd_conf(ent_conf),
    .wr_en(wr_en), .wr_idx(idx), .wr_tag(tag), .wr_addr(load_addr),
    .wr_stride(wr_stride), .wr_conf(wr_conf)
  );

  lsp_classify #(
    .TAG_W(TAG_W), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .CONF_W(CONF_W),
    .MAX_STRIDE(MAX_STRIDE), .CONF_FIRE(CONF_FIRE)
  ) u_classify (
    .load_valid(load_valid), .load_tag(tag), .load_addr(load_addr),
    .ent_valid(ent_valid), .ent_tag(ent_tag), .ent_addr(ent_addr),
    .ent_stride(ent_stride), .ent_conf(ent_conf),
    .ev(ev), .wr_en(wr_en), .wr_stride(wr_stride), .wr_conf(wr_conf),
    .fire(fire), .target(target)
  );

  lsp_issue #(.ADDR_W(ADDR_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .fire(fire), .target(target),
    .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  assign ev_miss     = (ev == EV_MISS);
  assign ev_zero     = (ev == EV_ZERO);
  assign ev_far      = (ev == EV_FAR);
  assign ev_restride = (ev == EV_NEWSTRIDE);

  function automatic logic near(input logic [ADDR_W-1:0] d);
    logic signed [ADDR_W:0] s;
    s = {d[ADDR_W-1], d};
    return (s <= (ADDR_W+1)'(MAX_STRIDE)) && (s >= -(ADDR_W+1)'(MAX_STRIDE));
  endfunction

  assert_pf_follows_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(load_valid));

  assert_miss_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> !pf_valid);

  assert_restride_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_restride |=> !pf_valid);

  assert_far_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_far |=> !pf_valid);

  assert_zero_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zero |=> !pf_valid);

  assert_pf_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_addr != $past(load_addr)));

  assert_pf_within_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> near(pf_addr - $past(load_addr)));

endmodule

// File: tb/load_stride_prefetcher_test.sv
`timescale 1ns/1ps
module load_stride_prefetcher_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_valid = 1'b0;
  logic [31:0] load_pc = '0;
  logic [31:0] load_addr = '0;
  logic        pf_valid;
  logic [31:0] pf_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  load_stride_prefetcher uut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_pc(load_pc),
    .load_addr(load_addr), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Present one load, then look at the outputs one cycle later.
  task automatic do_load(input logic [31:0] pc, input logic [31:0] a,
                         input bit exp_v, input logic [31:0] exp_a, input string req);
    load_valid = 1'b1;
    load_pc    = pc;
    load_addr  = a;
    @(negedge clk);
    check({req, " pf_valid"}, {31'd0, pf_valid}, {31'd0, exp_v});
    if (exp_v) check({req, " pf_addr"}, pf_addr, exp_a);
  endtask

  task automatic idle(input int n);
    load_valid = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Train pc with n loads at constant stride s from base b; load k>=3 prefetches.
  task automatic run_stride(input logic [31:0] pc, input logic [31:0] b,
                            input int s, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      logic [31:0] a;
      a = b + 32'(k * s);
      do_load(pc, a, k >= 3, a + 32'(s), req);
    end
    idle(1);
  endtask

  task automatic t_reset;
    check("R1 reset pf_valid", {31'd0, pf_valid}, 32'd0);
    check("R1 reset pf_addr", pf_addr, 32'd0);
    do_load(32'h0000_0009, 32'h0000_4000, 1'b0, '0, "R1 first load misses");
    idle(1);
  endtask

  task automatic t_forward;
    run_stride(32'h0000_0104, 32'h0000_1000, 64, 6, "R5 forward stride");
  endtask

  task automatic t_backward;
    run_stride(32'h0000_0208, 32'h0000_8000, -128, 6, "R6 backward stride");
  endtask

  task automatic t_far;
    run_stride(32'h0000_003D, 32'h0002_0000, 2048, 5, "R7 stride 2048 tracked");
    for (int k = 0; k < 6; k++)
      do_load(32'h0000_030C, 32'h0001_0000 + 32'(k * 2049), 1'b0, '0, "R7 stride 2049 ignored");
    idle(1);
  endtask

  task automatic t_zero;
    for (int k = 0; k < 6; k++)
      do_load(32'h0000_040E, 32'h0000_7700, 1'b0, '0, "R8 zero stride");
    idle(1);
  endtask

  task automatic t_confidence;
    logic [31:0] a;
    a = 32'h0000_2000;
    do_load(32'h51, a, 1'b0, '0, "R3 miss allocates");
    for (int k = 0; k < 3; k++) begin
      a += 8;
      do_load(32'h51, a, k == 2, a + 8, "R4 stride 8");
    end
    for (int k = 0; k < 5; k++) begin
      a += 16;
      do_load(32'h51, a, k >= 2, a + 16, "R4 new stride relearn and saturate");
    end
    a += 24;
    do_load(32'h51, a, 1'b0, '0, "R4 mismatch after saturation clears");
    a += 24;
    do_load(32'h51, a, 1'b0, '0, "R4 confidence one after clear");
    a += 24;
    do_load(32'h51, a, 1'b1, a + 24, "R4 confidence two fires");
    idle(1);
  endtask

  task automatic t_alias;
    for (int k = 0; k < 3; k++)
      do_load(32'h062, 32'h0000_3000 + 32'(4 * k), 1'b0, '0, "R2 train");
    do_load(32'h162, 32'h0000_9000, 1'b0, '0, "R2 alias miss");
    do_load(32'h062, 32'h0000_300C, 1'b0, '0, "R2 evicted no prefetch");
    idle(1);
  endtask

  task automatic t_interleave;
    for (int k = 0; k < 5; k++) begin
      do_load(32'h0A3, 32'h0000_5000 + 32'(32 * k), k >= 3,
              32'h0000_5000 + 32'(32 * (k + 1)), "R10 pc A");
      do_load(32'h0B5, 32'h0000_6000 - 32'(16 * k), k >= 3,
              32'h0000_6000 - 32'(16 * (k + 1)), "R10 pc B");
    end
    idle(1);
  endtask

  task automatic t_single;
    logic [31:0] a;
    a = 32'hFFFF_FF80;
    for (int k = 0; k < 4; k++) begin
      do_load(32'h0C6, a, k == 3, a + 32'h40, "R5 wrap");
      a += 32'h40;
    end
    idle(0);
    load_valid = 1'b0;
    @(negedge clk);
    check("R9 no prefetch without load", {31'd0, pf_valid}, 32'd0);
    @(negedge clk);
    check("R9 still idle", {31'd0, pf_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_forward();
    t_backward();
    t_far();
    t_zero();
    t_confidence();
    t_alias();
    t_interleave();
    t_single();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule